// File: doc/BRIEF.md
# UART Line Status Error Tracker

This block derives two bits of a UART line status register: the transmitter-idle bit and the aggregated receive-error bit. It holds the receive queue itself: a 16-entry FIFO in which every entry carries one received character and three error flags. Each cycle it counts how many queued entries are errored. The error bit reports that count through a sticky flag. A status-register read clears that flag only when no errored entry is left in the queue.

A legacy mode, selected when `fifo_mode` is low, keeps the error bit at zero. The transmitter-idle bit is decoded with no delay from two occupancy inputs. One input covers the transmit holding register, or the transmit FIFO in FIFO mode. The other covers the transmit shift register. The serial shifters, the baud generator and the remaining status bits live elsewhere.

Top module: `lsr_err_tracker`

## Requirements
- R1: `lsr_xmit_empty` is 1 in the same cycle exactly when `thr_busy` and `tsr_busy` are both 0, in either mode. It is 0 whenever either input is 1.
- R2: While `fifo_mode` is 0, `lsr_fifo_err` reads 0 from the cycle after that mode is sampled, whatever the queued entries carry.
- R3: A push to a full queue (16 entries) with no pop in the same cycle is ignored: the level and the contents are unchanged. A pop from an empty queue is ignored.
- R4: `rx_head_data` and `rx_head_flags` always present the oldest queued entry. Entries leave in the order they arrived. Flag bit 0 is parity error, bit 1 is framing error and bit 2 is break. An entry is errored when any of these bits is 1.
- R5: In FIFO mode, an accepted push of an errored entry makes `lsr_fifo_err` read 1 from the next cycle.
- R6: A cycle with `lsr_read` high clears `lsr_fifo_err` from the next cycle only if no errored entry remains in the queue after that cycle's push and pop. Otherwise the bit stays 1.
- R7: Once set in FIFO mode, `lsr_fifo_err` stays 1 without a read, even after every errored entry has been popped.
- R8: When a push and a pop are both accepted in the same cycle, the count of errored entries reflects both. An errored entry that replaces another errored entry keeps the bit set across a read.
- R9: After reset the queue is empty (`rx_level` = 0) and `lsr_fifo_err` is 0. `rx_level` then equals the number of queued entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = legacy single-character mode |
| rx_push | input | 1 | Write a received entry into the queue |
| rx_push_data | input | 8 | Received character |
| rx_push_flags | input | 3 | Error flags of the pushed entry: bit0 parity, bit1 framing, bit2 break |
| rx_pop | input | 1 | Remove the oldest entry |
| rx_head_data | output | 8 | Character of the oldest entry |
| rx_head_flags | output | 3 | Error flags of the oldest entry |
| rx_level | output | 5 | Number of queued entries |
| thr_busy | input | 1 | Transmit holding register (or transmit FIFO) holds data |
| tsr_busy | input | 1 | Transmit shift register holds data |
| lsr_read | input | 1 | Strobe: the line status register is being read |
| lsr_xmit_empty | output | 1 | Transmitter idle bit |
| lsr_fifo_err | output | 1 | Receive queue error bit |

## Verification
`lsr_xmit_empty` has no register on its path. The bench samples it 1 ns after driving the busy inputs, before the next clock edge. Every other result is due one cycle after the stimulus: the level, the head entry and the error bit each pass through exactly one register. Inputs are applied on a falling edge, and these outputs are compared on the following falling edge against a bench model. The model has already applied that cycle's pop, push and read, so each comparison lands in the cycle the requirement names.

// File: rtl/lsr_trk_pkg.sv
package lsr_trk_pkg;

  // Error flag bit positions within an entry
  localparam int FLG_PARITY  = 0;
  localparam int FLG_FRAMING = 1;
  localparam int FLG_BREAK   = 2;
  localparam int FLG_W       = 3;

  typedef logic [FLG_W-1:0] err_flags_t;

  // An entry counts as errored when any of its flags is set
  function automatic logic entry_errored(input err_flags_t f);
    return f[FLG_PARITY] | f[FLG_FRAMING] | f[FLG_BREAK];
  endfunction

  // Errored-entry count after one cycle of push and pop
  function automatic logic [15:0] cnt_step(input logic [15:0] c,
                                           input logic inc,
                                           input logic dec);
    return c + 16'(inc) - 16'(dec);
  endfunction

  // Sticky error bit: re-armed while errored entries remain, cleared by a read
  function automatic logic sticky_next(input logic mode,
                                       input logic remain,
                                       input logic cur,
                                       input logic rd);
    return mode & (remain | (cur & ~rd));
  endfunction

endpackage

// File: rtl/lsr_rx_queue.sv
module lsr_rx_queue
  import lsr_trk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  err_flags_t        push_flags,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output err_flags_t        head_flags,
  output logic [CNT_W-1:0]  level,
  output logic              push_ok,
  output logic              pop_ok
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DATA_W-1:0] data_mem [DEPTH];
  err_flags_t        flag_mem [DEPTH];
  logic full, empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wr_ptr == PTR_W'(g)) begin
        data_mem[g] <= push_data;
        flag_mem[g] <= push_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      if (push_ok && !pop_ok)      level <= level + CNT_W'(1);
      else if (pop_ok && !push_ok) level <= level - CNT_W'(1);
    end
  end

  assign head_data  = data_mem[rd_ptr];
  assign head_flags = flag_mem[rd_ptr];

endmodule

// File: rtl/lsr_err_count.sv
module lsr_err_count
  import lsr_trk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             inc,
  input  logic             dec,
  input  logic             lsr_read,
  output logic [CNT_W-1:0] err_cnt,
  output logic             fifo_err
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             remain;

  assign cnt_nxt = CNT_W'(cnt_step(16'(err_cnt), inc, dec));
  assign remain  = (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      fifo_err <= 1'b0;
    end else begin
      err_cnt  <= cnt_nxt;
      fifo_err <= sticky_next(fifo_mode, remain, fifo_err, lsr_read);
    end
  end

endmodule

// File: rtl/lsr_tx_idle.sv
module lsr_tx_idle (
  input  logic thr_busy,
  input  logic tsr_busy,
  output logic xmit_empty
);

  // Same rule in both modes: holding stage and shifter must both be empty
  assign xmit_empty = ~(thr_busy | tsr_busy);

endmodule

// File: rtl/lsr_err_tracker.sv
module lsr_err_tracker
  import lsr_trk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic [FLG_W-1:0]  rx_push_flags,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_head_data,
  output logic [FLG_W-1:0]  rx_head_flags,
  output logic [CNT_W-1:0]  rx_level,
  input  logic              thr_busy,
  input  logic              tsr_busy,
  input  logic              lsr_read,
  output logic              lsr_xmit_empty,
  output logic              lsr_fifo_err
);

  // Named internal events, also watched by the checker
  logic             push_ok, pop_ok;
  logic             push_errored, pop_errored;
  logic [CNT_W-1:0] err_cnt;

  lsr_rx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_push_data),
    .push_flags(rx_push_flags),
    .pop       (rx_pop),
    .head_data (rx_head_data),
    .head_flags(rx_head_flags),
    .level     (rx_level),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  assign push_errored = entry_errored(rx_push_flags);
  assign pop_errored  = entry_errored(rx_head_flags);

  lsr_err_count #(.DEPTH(DEPTH)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_mode),
    .inc      (push_ok & push_errored),
    .dec      (pop_ok & pop_errored),
    .lsr_read (lsr_read),
    .err_cnt  (err_cnt),
    .fifo_err (lsr_fifo_err)
  );

  lsr_tx_idle u_tx (
    .thr_busy  (thr_busy),
    .tsr_busy  (tsr_busy),
    .xmit_empty(lsr_xmit_empty)
  );

endmodule

// File: rtl/lsr_err_tracker_chk.sv
module lsr_err_tracker_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             lsr_read,
  input logic             thr_busy,
  input logic             tsr_busy,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             push_errored,
  input logic             pop_errored,
  input logic [CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0] level,
  input logic             fifo_err,
  input logic             xmit_empty
);

  p_busy_blocks_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_busy || tsr_busy) |-> !xmit_empty);

  p_legacy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !fifo_err);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH) && !pop_ok) |=> level == CNT_W'(DEPTH));

  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && push_ok && push_errored) |=> fifo_err);

  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && err_cnt == '0 && !(push_ok && push_errored)) |=> !fifo_err);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && fifo_err && !lsr_read) |=> fifo_err);

  p_swap_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && push_errored && pop_ok && pop_errored) |=> $stable(err_cnt));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= level);

endmodule

bind lsr_err_tracker lsr_err_tracker_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_mode   (fifo_mode),
  .lsr_read    (lsr_read),
  .thr_busy    (thr_busy),
  .tsr_busy    (tsr_busy),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok),
  .push_errored(push_errored),
  .pop_errored (pop_errored),
  .err_cnt     (err_cnt),
  .level       (rx_level),
  .fifo_err    (lsr_fifo_err),
  .xmit_empty  (lsr_xmit_empty)
);

// File: tb/lsr_err_tracker_tb.sv
`timescale 1ns/1ps
module lsr_err_tracker_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_push_data = '0;
  logic [2:0] rx_push_flags = '0;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_head_data;
  logic [2:0] rx_head_flags;
  logic [4:0] rx_level;
  logic       thr_busy = 1'b0;
  logic       tsr_busy = 1'b0;
  logic       lsr_read = 1'b0;
  logic       lsr_xmit_empty;
  logic       lsr_fifo_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0] mq[$];   // {flags, data}
  bit          m_err = 1'b0;

  always #2.5 clk = ~clk;

  lsr_err_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_flags(rx_push_flags),
    .rx_pop(rx_pop), .rx_head_data(rx_head_data), .rx_head_flags(rx_head_flags),
    .rx_level(rx_level), .thr_busy(thr_busy), .tsr_busy(tsr_busy),
    .lsr_read(lsr_read), .lsr_xmit_empty(lsr_xmit_empty), .lsr_fifo_err(lsr_fifo_err)
  );

  function automatic int count_errored();
    int n = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  function automatic bit exp_idle(bit tb, bit ts);
    return !(tb || ts);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge, then compare on the next falling edge
  task automatic step(input bit m, input bit pu, input logic [7:0] d,
                      input logic [2:0] f, input bit po, input bit rd,
                      input bit tb, input bit ts);
    int sz;
    bit pok, puk;
    fifo_mode = m; rx_push = pu; rx_push_data = d; rx_push_flags = f;
    rx_pop = po; lsr_read = rd; thr_busy = tb; tsr_busy = ts;
    #1;
    chk(int'(lsr_xmit_empty), int'(exp_idle(tb, ts)), "R1 xmit_empty");
    sz  = mq.size();
    pok = po && sz > 0;
    puk = pu && (sz < DEPTH || pok);
    if (pok) void'(mq.pop_front());
    if (puk) mq.push_back({f, d});
    m_err = m && (count_errored() != 0 || (m_err && !rd));
    @(negedge clk);
    chk(int'(rx_level), mq.size(), "R9/R3 level");
    chk(int'(lsr_fifo_err), int'(m_err), "R2/R5/R6/R7 fifo_err");
    if (mq.size() > 0) begin
      chk(int'(rx_head_data), int'(mq[0][7:0]), "R4 head data");
      chk(int'(rx_head_flags), int'(mq[0][10:8]), "R4 head flags");
    end
  endtask

  task automatic idle(input bit m);
    step(m, 0, 8'h00, 3'b000, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fifo_mode = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(int'(rx_level), 0, "R9 reset level");
    chk(int'(lsr_fifo_err), 0, "R9 reset fifo_err");

    // R1: all busy combinations
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0);

    // R5 then R6/R8: errored entry queued behind the one read out
    step(1, 1, 8'hA1, 3'b001, 0, 0, 0, 0);          // R5 parity entry
    chk(int'(lsr_fifo_err), 1, "R5 set after errored push");
    step(1, 0, 0, 0, 0, 1, 0, 0);                   // R6 read, one still queued
    chk(int'(lsr_fifo_err), 1, "R6 read keeps bit");
    step(1, 1, 8'hB2, 3'b010, 1, 1, 0, 0);          // R8 swap errored for errored
    chk(int'(lsr_fifo_err), 1, "R8 swap keeps bit across read");
    step(1, 0, 0, 0, 1, 0, 0, 0);                   // R7 pop last, no read
    chk(int'(lsr_fifo_err), 1, "R7 sticky without read");
    step(1, 0, 0, 0, 0, 1, 0, 0);                   // R6 read with none left
    chk(int'(lsr_fifo_err), 0, "R6 read clears");

    // R8: clean push with errored pop and a read in one cycle
    step(1, 1, 8'hC3, 3'b100, 0, 0, 0, 0);
    step(1, 1, 8'hC4, 3'b000, 1, 1, 0, 0);
    chk(int'(lsr_fifo_err), 0, "R8 swap to clean clears on read");
    step(1, 0, 0, 0, 1, 0, 0, 0);

    // R2: legacy mode masks the bit
    step(0, 1, 8'hD5, 3'b111, 0, 0, 0, 0);
    chk(int'(lsr_fifo_err), 0, "R2 legacy zero");
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk(int'(lsr_fifo_err), 1, "R2 FIFO mode shows queued error");
    step(1, 0, 0, 0, 1, 1, 0, 0);

    // R3: overflow and underflow ignored
    for (int i = 0; i < DEPTH; i++) step(1, 1, 8'(i + 16), 3'b000, 0, 0, 0, 0);
    step(1, 1, 8'hEE, 3'b001, 0, 0, 0, 0);
    chk(int'(rx_level), DEPTH, "R3 push on full ignored");
    chk(int'(lsr_fifo_err), 0, "R3 rejected errored push has no effect");
    step(1, 1, 8'hF0, 3'b010, 1, 0, 0, 0);          // full, push with pop accepted
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 1, 1, 0, 0);  // R4 order
    step(1, 0, 0, 0, 1, 0, 0, 0);
    chk(int'(rx_level), 0, "R3 pop on empty ignored");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      bit m = ($urandom % 10) != 0;
      bit pu = ($urandom % 2) != 0;
      bit po = ($urandom % 5) < 2;
      bit rd = ($urandom % 5) == 0;
      logic [2:0] f = (($urandom % 4) == 0) ? 3'($urandom % 7 + 1) : 3'b000;
      step(m, pu, 8'($urandom), f, po, rd, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule